// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It walks the memory device from power-up to a usable state. After a `start` pulse it checks the requested burst-length and CAS-latency codes. If they are valid, it holds the clock enable low for a programmable interval. It then raises the clock enable with a NOP on the command pins. After that it issues the mandatory command chain:

1. Extended-mode write that enables the DLL.
2. Base-mode write that resets the DLL.
3. Precharge of all banks.
4. A parameterised number of auto refreshes.
5. A final base-mode write carrying the operating burst length and CAS latency.

Every gap between commands is a down-count loaded from a per-interval cycle input. Every cycle with no command carries a NOP, or a deselect while the clock enable is still low.

The configuration and interval inputs are captured at the start. Once the last mode write has settled, `init_done` rises and stays high until reset, and the bus is left idle with NOPs for the normal traffic logic to take over. An unsupported configuration sets `cfg_err` instead. The block then parks with the clock enable low and the bus deselected.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset and until `start` is seen, `mem_cke` is 0, the bus is deselected (`mem_cs_n` = 1), and `init_done` and `cfg_err` are 0.
- R2: At the `start` cycle the burst code must be 1, 2 or 3 and the latency code must be 2, 3 or 6. Otherwise `cfg_err` goes to 1 and stays there until reset. In that state `mem_cke` stays 0, `mem_cs_n` stays 1 and `init_done` stays 0, and further `start` pulses have no effect.
- R3: With a valid start, `mem_cke` stays 0 with the bus deselected for max(`gap_pwr`,1) cycles. It then rises in a cycle whose bus carries a NOP.
- R4: After the clock enable rises, the commands issued are, in order:
  - load-mode to bank 01 with address 0;
  - load-mode to bank 00 with the DLL-reset word;
  - precharge with A10 = 1 and all other address and bank bits 0;
  - exactly REF_COUNT auto refreshes with address and bank 0;
  - load-mode to bank 00 with the operating word.
- R5: Command encodings on {cs_n, ras_n, cas_n, we_n} are load-mode 0000, precharge 0010, auto refresh 0001 and NOP 0111. Deselect is cs_n = 1. Load-mode uses only bank 00 (base) or 01 (extended).
- R6: The base mode word has A[2:0] = burst code, A3 = 0, A[6:4] = latency code and A8 = DLL reset (1 in the first base write, 0 in the last). All other address bits are 0.
- R7: The first load-mode follows the clock-enable rise cycle directly. Between later consecutive commands there are exactly max(T,1) NOP cycles. T is `gap_mrd` after a load-mode, `gap_rp` after the precharge and `gap_rfc` after a refresh.
- R8: No auto refresh is issued before the DLL-reset load-mode. Every refresh that counts toward REF_COUNT follows it.
- R9: `init_done` rises max(`gap_mrd`,1) cycles after the final load-mode. It then stays 1 with `mem_cke` = 1 and NOPs on the bus until reset.
- R10: Configuration and interval inputs are sampled only in the `start` cycle. Changing them later does not alter the command words or the gaps.
- R11: A `start` pulse while the sequence is running or after it has completed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the power-up sequence (one-cycle pulse) |
| cfg_burst_code | input | 3 | Burst length code (beats = 2^code) |
| cfg_cas_code | input | 3 | CAS latency code (2, 3, or 6 for 2.5) |
| gap_pwr | input | CNT_W | Cycles with clock enable low before it is raised |
| gap_mrd | input | CNT_W | Wait after each load-mode command |
| gap_rp | input | CNT_W | Wait after the precharge |
| gap_rfc | input | CNT_W | Wait after each auto refresh |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Sequence complete, held until reset |
| cfg_err | output | 1 | Unsupported configuration, held until reset |

## Verification
The bench targets the zero and one interval values, which must both give a single NOP. An off-by-one down-counter would show up there as a shortened or stretched gap. Latency code 6 must pass through unchanged into A[6:4], and the bench checks that the DLL-reset bit is set in the first base write and clear in the last. A design that mixed up the two words, or forgot A10 on the precharge, fails the address comparison for that command.

Inputs are changed and `start` is pulsed again both mid-sequence and after completion. A design that re-sampled its inputs or restarted would emit different words, extra commands or wrong gaps. Invalid burst and latency codes are driven, followed by a valid retry. A design that left the error state or raised the clock enable would be caught.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WR    = 4'b0100,
    CMD_RD    = 4'b0101,
    CMD_BST   = 4'b0110,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } bus_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PWR, ST_CKE,
    ST_EXT, ST_EXT_W,
    ST_DLLRST, ST_DLLRST_W,
    ST_PRE, ST_PRE_W,
    ST_REF, ST_REF_W,
    ST_OPMODE, ST_OPMODE_W,
    ST_DONE, ST_ERR
  } seq_state_e;

  localparam logic [1:0] BANK_BASE = 2'b00;
  localparam logic [1:0] BANK_EXT  = 2'b01;

  function automatic logic burst_code_ok(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd3);
  endfunction

  function automatic logic latency_code_ok(input logic [2:0] code);
    return (code == 3'd2) || (code == 3'd3) || (code == 3'd6);
  endfunction

  function automatic logic [15:0] base_mode_word(input logic [2:0] bl,
                                                 input logic [2:0] cl,
                                                 input logic dll_rst);
    logic [15:0] w;
    w      = '0;
    w[2:0] = bl;
    w[3]   = 1'b0;  // sequential burst order
    w[6:4] = cl;
    w[8]   = dll_rst;
    return w;
  endfunction

  function automatic logic [15:0] ext_mode_word();
    return 16'h0000;  // DLL enabled, normal drive
  endfunction

  function automatic logic [15:0] close_all_word();
    logic [15:0] w;
    w     = '0;
    w[10] = 1'b1;
    return w;
  endfunction

  function automatic logic is_wait_state(input seq_state_e s);
    return (s == ST_PWR) || (s == ST_EXT_W) || (s == ST_DLLRST_W) ||
           (s == ST_PRE_W) || (s == ST_REF_W) || (s == ST_OPMODE_W);
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  // A wait ends in the cycle the count is at or below one, so a loaded
  // value T yields max(T,1) wait cycles.
  assign expired = (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run && !expired) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && expired && !load) |=> (cnt <= CNT_W'(1)));
endmodule

// File: rtl/ddr_init_cfg.sv
module ddr_init_cfg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [2:0]       bl_in,
  input  logic [2:0]       cl_in,
  input  logic [CNT_W-1:0] mrd_in,
  input  logic [CNT_W-1:0] rp_in,
  input  logic [CNT_W-1:0] rfc_in,
  output logic             live_ok,
  output logic [2:0]       bl_q,
  output logic [2:0]       cl_q,
  output logic [CNT_W-1:0] mrd_q,
  output logic [CNT_W-1:0] rp_q,
  output logic [CNT_W-1:0] rfc_q
);
  import ddr_init_pkg::*;

  assign live_ok = burst_code_ok(bl_in) && latency_code_ok(cl_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bl_q  <= 3'd1;
      cl_q  <= 3'd2;
      mrd_q <= '0;
      rp_q  <= '0;
      rfc_q <= '0;
    end else if (capture) begin
      bl_q  <= bl_in;
      cl_q  <= cl_in;
      mrd_q <= mrd_in;
      rp_q  <= rp_in;
      rfc_q <= rfc_in;
    end
  end

  p_hold_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(bl_q) && $stable(cl_q) && $stable(mrd_q)));
endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm #(
  parameter int CNT_W     = 16,
  parameter int REF_COUNT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     cfg_ok,
  input  logic [CNT_W-1:0]         pwr_gap,
  input  logic [CNT_W-1:0]         mrd_gap,
  input  logic [CNT_W-1:0]         rp_gap,
  input  logic [CNT_W-1:0]         rfc_gap,
  output ddr_init_pkg::seq_state_e state,
  output logic                     capture,
  output logic                     done,
  output logic                     err
);
  import ddr_init_pkg::*;

  localparam int RC_W = $clog2(REF_COUNT + 1);

  seq_state_e       nxt;
  logic [RC_W-1:0]  ref_cnt;
  logic             dll_rst_done;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_run;
  logic             t_exp;

  assign capture = (state == ST_IDLE) && start;
  assign done    = (state == ST_DONE);
  assign err     = (state == ST_ERR);
  assign t_run   = is_wait_state(state);

  ddr_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .run      (t_run),
    .expired  (t_exp)
  );

  always_comb begin
    t_load = 1'b1;
    unique case (state)
      ST_IDLE:                       t_val = pwr_gap;
      ST_EXT, ST_DLLRST, ST_OPMODE:  t_val = mrd_gap;
      ST_PRE:                        t_val = rp_gap;
      ST_REF:                        t_val = rfc_gap;
      default: begin
        t_load = 1'b0;
        t_val  = '0;
      end
    endcase
    if (state == ST_IDLE && !(start && cfg_ok)) t_load = 1'b0;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (start) nxt = cfg_ok ? ST_PWR : ST_ERR;
      ST_PWR:      if (t_exp) nxt = ST_CKE;
      ST_CKE:      nxt = ST_EXT;
      ST_EXT:      nxt = ST_EXT_W;
      ST_EXT_W:    if (t_exp) nxt = ST_DLLRST;
      ST_DLLRST:   nxt = ST_DLLRST_W;
      ST_DLLRST_W: if (t_exp) nxt = ST_PRE;
      ST_PRE:      nxt = ST_PRE_W;
      ST_PRE_W:    if (t_exp) nxt = ST_REF;
      ST_REF:      nxt = ST_REF_W;
      ST_REF_W:    if (t_exp) nxt = (ref_cnt >= RC_W'(REF_COUNT)) ? ST_OPMODE : ST_REF;
      ST_OPMODE:   nxt = ST_OPMODE_W;
      ST_OPMODE_W: if (t_exp) nxt = ST_DONE;
      ST_DONE:     nxt = ST_DONE;
      ST_ERR:      nxt = ST_ERR;
      default:     nxt = ST_ERR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      ref_cnt      <= '0;
      dll_rst_done <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_DLLRST) dll_rst_done <= 1'b1;
      if (state == ST_REF)    ref_cnt <= ref_cnt + RC_W'(1);
    end
  end

  p_ref_after_dllrst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REF) |-> dll_rst_done);

  p_ref_total_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OPMODE) |-> (ref_cnt == RC_W'(REF_COUNT)));
endmodule

// File: rtl/ddr_init_cmd_drv.sv
module ddr_init_cmd_drv #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  ddr_init_pkg::seq_state_e state,
  input  logic [2:0]               bl,
  input  logic [2:0]               cl,
  output logic                     cke,
  output ddr_init_pkg::bus_cmd_e   cmd,
  output logic [BA_W-1:0]          ba,
  output logic [ADDR_W-1:0]        addr
);
  import ddr_init_pkg::*;

  always_comb begin
    cke  = 1'b1;
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    unique case (state)
      ST_IDLE, ST_PWR, ST_ERR: begin
        cke = 1'b0;
        cmd = CMD_DESEL;
      end
      ST_EXT: begin
        cmd  = CMD_LMR;
        ba   = BA_W'(BANK_EXT);
        addr = ADDR_W'(ext_mode_word());
      end
      ST_DLLRST: begin
        cmd  = CMD_LMR;
        ba   = BA_W'(BANK_BASE);
        addr = ADDR_W'(base_mode_word(bl, cl, 1'b1));
      end
      ST_PRE: begin
        cmd  = CMD_PRE;
        addr = ADDR_W'(close_all_word());
      end
      ST_REF:  cmd = CMD_REF;
      ST_OPMODE: begin
        cmd  = CMD_LMR;
        ba   = BA_W'(BANK_BASE);
        addr = ADDR_W'(base_mode_word(bl, cl, 1'b0));
      end
      default: cmd = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int CNT_W     = 16,
  parameter int REF_COUNT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cfg_burst_code,
  input  logic [2:0]        cfg_cas_code,
  input  logic [CNT_W-1:0]  gap_pwr,
  input  logic [CNT_W-1:0]  gap_mrd,
  input  logic [CNT_W-1:0]  gap_rp,
  input  logic [CNT_W-1:0]  gap_rfc,
  output logic              mem_cke,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done,
  output logic              cfg_err
);
  import ddr_init_pkg::*;

  seq_state_e       state;
  bus_cmd_e         cmd;
  logic             capture;
  logic             live_ok;
  logic [2:0]       bl_q;
  logic [2:0]       cl_q;
  logic [CNT_W-1:0] mrd_q;
  logic [CNT_W-1:0] rp_q;
  logic [CNT_W-1:0] rfc_q;

  ddr_init_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .bl_in   (cfg_burst_code),
    .cl_in   (cfg_cas_code),
    .mrd_in  (gap_mrd),
    .rp_in   (gap_rp),
    .rfc_in  (gap_rfc),
    .live_ok (live_ok),
    .bl_q    (bl_q),
    .cl_q    (cl_q),
    .mrd_q   (mrd_q),
    .rp_q    (rp_q),
    .rfc_q   (rfc_q)
  );

  ddr_init_fsm #(.CNT_W(CNT_W), .REF_COUNT(REF_COUNT)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cfg_ok  (live_ok),
    .pwr_gap (gap_pwr),
    .mrd_gap (mrd_q),
    .rp_gap  (rp_q),
    .rfc_gap (rfc_q),
    .state   (state),
    .capture (capture),
    .done    (init_done),
    .err     (cfg_err)
  );

  ddr_init_cmd_drv #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_drv (
    .state (state),
    .bl    (bl_q),
    .cl    (cl_q),
    .cke   (mem_cke),
    .cmd   (cmd),
    .ba    (mem_ba),
    .addr  (mem_addr)
  );

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd;

  // Named bus events for the checks below
  logic bus_nop, bus_cmd, bus_lmr;
  assign bus_nop = !mem_cs_n && mem_ras_n && mem_cas_n && mem_we_n;
  assign bus_cmd = mem_cke && !mem_cs_n && !bus_nop;
  assign bus_lmr = bus_cmd && !mem_ras_n && !mem_cas_n && !mem_we_n;

  p_cke_rise_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cke) |-> (mem_cs_n || bus_nop));

  p_cmd_then_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd |=> bus_nop);

  p_lmr_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lmr |-> (mem_ba == BA_W'(0) || mem_ba == BA_W'(1)));

  p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!mem_cke && mem_cs_n && !init_done));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> (init_done && mem_cke && bus_nop));

  p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

// File: tb/tb_ddr_init_seq.sv
module tb_ddr_init_seq;
  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int CNT_W  = 16;
  localparam int NREF   = 2;

  localparam int K_CKE = 0, K_LMR = 1, K_PRE = 2, K_REF = 3, K_DONE = 4;

  typedef struct {
    int    kind;
    int    ba;
    int    addr;
    int    gap;
    string tag;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [2:0] bl = 3'd1, cl = 3'd2;
  logic [CNT_W-1:0] tpw = 0, tmr = 0, trp = 0, trf = 0;
  logic cke, cs_n, ras_n, cas_n, we_n, done, err;
  logic [BA_W-1:0] ba;
  logic [ADDR_W-1:0] addr;

  int n_chk = 0, n_bad = 0;
  int gap = 0;
  exp_t q[$];

  always #10 clk = ~clk;  // 50 MHz

  ddr_init_seq #(.ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W), .REF_COUNT(NREF)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_burst_code(bl), .cfg_cas_code(cl),
    .gap_pwr(tpw), .gap_mrd(tmr), .gap_rp(trp), .gap_rfc(trf),
    .mem_cke(cke), .mem_cs_n(cs_n), .mem_ras_n(ras_n), .mem_cas_n(cas_n),
    .mem_we_n(we_n), .mem_ba(ba), .mem_addr(addr),
    .init_done(done), .cfg_err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mx1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // Mode word restated: burst code low, latency in the nibble above, DLL reset at bit 8
  function automatic int mode_word(input int b, input int c, input int rst);
    return b + c * 16 + rst * 256;
  endfunction

  task automatic push(input int k, input int b, input int a, input int g, input string t);
    exp_t e;
    e.kind = k; e.ba = b; e.addr = a; e.gap = g; e.tag = t;
    q.push_back(e);
  endtask

  task automatic run_seq(input int b, input int c, input int p, input int m,
                         input int r, input int f);
    push(K_CKE, 0, 0, mx1(p), "R3");
    push(K_LMR, 1, 0, 0, "R4");
    push(K_LMR, 0, mode_word(b, c, 1), mx1(m), "R6");
    push(K_PRE, 0, 1024, mx1(m), "R4");
    for (int i = 0; i < NREF; i++)
      push(K_REF, 0, 0, (i == 0) ? mx1(r) : mx1(f), "R8");
    push(K_LMR, 0, mode_word(b, c, 0), mx1(f), "R6");
    push(K_DONE, 0, 0, mx1(m), "R9");
    @(negedge clk);
    bl = 3'(b); cl = 3'(c);
    tpw = CNT_W'(p); tmr = CNT_W'(m); trp = CNT_W'(r); trf = CNT_W'(f);
    start = 1; gap = 0;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, tag, done, 1);
    chk(q.size() == 0, "R4 queue drained", q.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Monitor: samples 5 ns after each rising edge and compares events with the queue
  initial begin
    bit cke_prev = 0, done_prev = 0;
    forever begin
      @(posedge clk);
      #5;
      if (!rst_n) begin
        cke_prev = 0; done_prev = 0;
      end else begin
        int k;
        bit ev;
        ev = 1;
        k = -1;
        if (cke && !cke_prev) begin
          k = K_CKE;
          chk(!cs_n && ras_n && cas_n && we_n, "R3 NOP at CKE rise",
              {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        end else if (cke && !cs_n && !(ras_n && cas_n && we_n)) begin
          case ({ras_n, cas_n, we_n})
            3'b000:  k = K_LMR;
            3'b010:  k = K_PRE;
            3'b001:  k = K_REF;
            default: k = 9;
          endcase
        end else if (done && !done_prev) begin
          k = K_DONE;
        end else begin
          ev = 0;
        end
        if (ev) begin
          if (q.size() == 0) begin
            chk(0, "R11 unexpected event", k, -1);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(k == e.kind, {e.tag, " R5 command"}, k, e.kind);
            if (e.kind != K_DONE && e.kind != K_CKE) begin
              chk(int'(ba) == e.ba, {e.tag, " bank"}, int'(ba), e.ba);
              chk(int'(addr) == e.addr, {e.tag, " address"}, int'(addr), e.addr);
            end
            chk(gap == e.gap, (e.kind == K_CKE) ? "R3 gap" : "R7 gap", gap, e.gap);
          end
          gap = 0;
        end else begin
          gap++;
        end
        cke_prev = cke;
        done_prev = done;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: quiet after reset
    chk(cke == 0, "R1 cke", cke, 0);
    chk(cs_n == 1, "R1 cs_n", cs_n, 1);
    chk(done == 0 && err == 0, "R1 flags", {done, err}, 0);

    // Main run; inputs disturbed and start re-pulsed mid-run (R10, R11)
    run_seq(3, 2, 5, 2, 3, 4);
    repeat (3) @(negedge clk);
    bl = 3'd1; cl = 3'd3; tmr = 9; trp = 9; trf = 9; tpw = 9;
    start = 1;
    @(negedge clk);
    start = 0;
    wait_done("R9 run A done");
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    chk(done == 1 && cke == 1, "R9 done held", {done, cke}, 2'b11);
    chk(!cs_n && ras_n && cas_n && we_n, "R11 NOP after done",
        {cs_n, ras_n, cas_n, we_n}, 4'b0111);

    // CAS latency 2.5 code, zero intervals
    do_reset();
    run_seq(1, 6, 0, 0, 0, 0);
    wait_done("R9 run B done");

    // Interval value one
    do_reset();
    run_seq(2, 3, 1, 1, 1, 1);
    wait_done("R9 run C done");

    // Invalid configurations
    do_reset();
    @(negedge clk);
    bl = 3'd0; cl = 3'd2; start = 1;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    chk(err == 1, "R2 bad burst code", err, 1);
    chk(cke == 0 && cs_n == 1, "R2 quiet bus", {cke, cs_n}, 2'b01);
    bl = 3'd2; start = 1;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    chk(err == 1 && done == 0 && cke == 0, "R2 error held", {err, done, cke}, 3'b100);

    do_reset();
    @(negedge clk);
    bl = 3'd3; cl = 3'd4; start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    chk(err == 1, "R2 bad latency code", err, 1);

    do_reset();
    @(negedge clk);
    bl = 3'd7; cl = 3'd3; start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    chk(err == 1 && cke == 0, "R2 burst code 7", {err, cke}, 2'b10);

    do_reset();
    repeat (2) @(negedge clk);
    chk(err == 0 && cke == 0 && cs_n == 1, "R1 reset clears error", {err, cke, cs_n}, 3'b001);
    finish_up();
  end
endmodule